// File: doc/BRIEF.md
# Serial Link Fault Injector

This block is placed on the output of a serial transmitter and injects faults into the link without any change to the transmitter. The transmitter hands over a 32-bit frame with a one-cycle start strobe. The injector holds the frame for the whole transmission window and sends it least significant bit first on a serial line, one bit per cycle. When the window closes, it delivers the frame the receiver actually saw, with any fault applied.

A fault is set up before a run with a single configuration load. The load gives a mode, an activation time, a duration (zero means the fault stays on) and one parameter word. The parameter word carries the stuck level, the oscillation half-period or the drift offset, depending on the mode. Time is counted in clock cycles from the load. A fault that is in force during a bit slot changes that slot's line value. A bit-corruption fault therefore inverts the bit that is under way when the fault fires. The delivered frame is assembled from the line values of the 32 slots. Drift is modelled as an offset added to the delivered frame.

Top module: `serial_fault_injector`

## Requirements
- R1: After reset the line rests at the idle level 1, and `rx_valid`, `fault_active`, `disc_flag` and `corrupt_count` are all 0.
- R2: A `tx_start` pulse seen while idle captures `tx_frame`. In the k-th cycle after that pulse (k = 1..32), the line carries bit k-1 of the frame. `rx_valid` is high for exactly one cycle, the 33rd cycle after the pulse, and `rx_frame` then holds the 32 line values in slot order.
- R3: The cycle timer reads 0 in the cycle after `cfg_load` and then counts up. The fault is in force while the timer is at or above the start and, if the duration is nonzero, below start plus duration. `fault_active` shows this for any mode other than none. Mode codes: 0 none, 1 short, 2 stuck, 3 disconnect, 4 bit corruption, 5 drift, 6 oscillation.
- R4: While a short is in force, the line is 0.
- R5: While a stuck fault is in force, the line equals bit 0 of the parameter word.
- R6: While a disconnect is in force, the line is held at the idle level 1 and `disc_flag` is high.
- R7: While a bit-corruption fault is in force during a slot, that slot's bit is inverted on the line and in the delivered frame. Outside the frame window the line stays idle.
- R8: If a drift fault is in force in the last slot, the delivered frame is the received bits plus the parameter word, modulo 2^32. The line itself is unaffected.
- R9: While an oscillation fault is in force, the line starts at 0 and toggles every N cycles, where N is the low 8 bits of the parameter word (0 is treated as 1). The count restarts whenever the fault is not in force.
- R10: A `tx_start` that arrives while a frame is in flight is ignored. The frame in flight is delivered unchanged and no extra frame follows.
- R11: `corrupt_count` rises by one, one cycle after each delivered frame that differs from the captured frame, and never rises otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_load | input | 1 | Load fault configuration and restart the timer |
| cfg_mode | input | 3 | Fault mode code |
| cfg_start | input | 16 | Activation time in cycles after load |
| cfg_dur | input | 16 | Fault duration in cycles, 0 = permanent |
| cfg_param | input | 32 | Stuck level / oscillation half-period / drift offset |
| tx_start | input | 1 | Frame start strobe from the transmitter |
| tx_frame | input | 32 | Frame to transmit |
| line_out | output | 1 | Serial line towards the receiver |
| rx_valid | output | 1 | Delivered frame strobe |
| rx_frame | output | 32 | Frame as seen on the link |
| fault_active | output | 1 | A fault is in force |
| disc_flag | output | 1 | Disconnect fault in force |
| corrupt_count | output | 16 | Number of delivered frames that differ from the captured frame |

## Verification
The bench drives inputs on the falling edge, so the first tx_start cycle is timer value 0 and slot p falls at timer p+1. The line is sampled at each of the 32 following falling edges. `rx_valid` and `rx_frame` are checked at the falling edge 33 cycles after the start strobe, and `corrupt_count` one cycle later, once all vectors have been applied. Window timing is checked one cycle at a time against timer values counted from the load, and the busy-ignore case watches for any stray strobe over 40 more cycles.

// File: rtl/fi_pkg.sv
// Shared types for the serial fault injector.
package fi_pkg;
    typedef enum logic [2:0] {
        FM_NONE    = 3'd0,
        FM_SHORT   = 3'd1,
        FM_STUCK   = 3'd2,
        FM_DISC    = 3'd3,
        FM_CORRUPT = 3'd4,
        FM_DRIFT   = 3'd5,
        FM_OSC     = 3'd6
    } fault_mode_e;

    localparam logic IDLE_LEVEL = 1'b1;
endpackage

// File: rtl/fi_window.sv
// Activation window: counts cycles from the configuration load and reports
// whether the programmed fault interval covers the current cycle.
// Assumes: duration 0 means the fault never expires; the timer saturates.
module fi_window #(
    parameter int TIME_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [TIME_W-1:0] start_in,
    input  logic [TIME_W-1:0] dur_in,
    output logic              active
);
    logic [TIME_W-1:0] timer_q, start_q, dur_q;
    logic              armed_q;
    logic [TIME_W:0]   end_sum;

    // Timer, arming flag and window bounds.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            timer_q <= '0;
            start_q <= '0;
            dur_q   <= '0;
            armed_q <= 1'b0;
        end else if (load) begin
            timer_q <= '0;
            start_q <= start_in;
            dur_q   <= dur_in;
            armed_q <= 1'b1;
        end else if (timer_q != '1) begin
            timer_q <= timer_q + 1'b1;
        end
    end

    // Window compare on the current timer value.
    always_comb begin
        end_sum = {1'b0, start_q} + {1'b0, dur_q};
        active  = armed_q && (timer_q >= start_q) &&
                  ((dur_q == '0) || ({1'b0, timer_q} < end_sum));
    end
endmodule

// File: rtl/fi_osc.sv
// Oscillation source: level starts at 0 and toggles every PERIOD cycles
// while enabled; clears whenever disabled. Assumes period 0 acts as 1.
module fi_osc #(
    parameter int OSC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [OSC_W-1:0] period,
    output logic             level
);
    logic [OSC_W-1:0] cnt_q, per_m1;

    // Terminal count of the half-period.
    always_comb per_m1 = (period == '0) ? '0 : period - 1'b1;

    // Half-period counter and output level.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            cnt_q <= '0;
            level <= 1'b0;
        end else if (cnt_q >= per_m1) begin
            cnt_q <= '0;
            level <= ~level;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/fi_frame.sv
// Frame holder: captures a frame on start, presents one bit per slot,
// collects the line value of each slot and delivers the collected frame
// (plus optional drift offset) after the last slot.
// Assumes: starts during a frame in flight are dropped.
module fi_frame #(
    parameter int FRAME_BITS = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic [FRAME_BITS-1:0] frame_in,
    input  logic                  line_bit,
    input  logic                  drift_en,
    input  logic [FRAME_BITS-1:0] drift_off,
    output logic                  busy,
    output logic                  cur_bit,
    output logic                  rx_valid,
    output logic [FRAME_BITS-1:0] rx_frame,
    output logic                  changed
);
    localparam int POS_W = $clog2(FRAME_BITS);
    localparam logic [POS_W-1:0] LAST = POS_W'(FRAME_BITS - 1);

    logic [POS_W-1:0]      pos_q;
    logic [FRAME_BITS-1:0] held_q, coll_q, coll_next, delivered;

    // Slot bit and the frame as it will be delivered.
    always_comb begin
        cur_bit          = held_q[pos_q];
        coll_next        = coll_q;
        coll_next[pos_q] = line_bit;
        delivered        = coll_next + (drift_en ? drift_off : '0);
    end

    // Capture, slot stepping and delivery.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy     <= 1'b0;
            pos_q    <= '0;
            held_q   <= '0;
            coll_q   <= '0;
            rx_valid <= 1'b0;
            rx_frame <= '0;
            changed  <= 1'b0;
        end else begin
            rx_valid <= 1'b0;
            changed  <= 1'b0;
            if (!busy && start) begin
                busy   <= 1'b1;
                pos_q  <= '0;
                held_q <= frame_in;
                coll_q <= '0;
            end else if (busy) begin
                coll_q <= coll_next;
                if (pos_q == LAST) begin
                    busy     <= 1'b0;
                    rx_valid <= 1'b1;
                    rx_frame <= delivered;
                    changed  <= (delivered != held_q);
                end else begin
                    pos_q <= pos_q + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/serial_fault_injector.sv
// Serial link fault injector: holds configuration, selects the line value
// per mode while the fault window is open, and counts altered frames.
// Assumes configuration is loaded between frames.
module serial_fault_injector #(
    parameter int FRAME_BITS = 32,
    parameter int TIME_W     = 16,
    parameter int OSC_W      = 8,
    parameter int CNT_W      = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_load,
    input  logic [2:0]            cfg_mode,
    input  logic [TIME_W-1:0]     cfg_start,
    input  logic [TIME_W-1:0]     cfg_dur,
    input  logic [FRAME_BITS-1:0] cfg_param,
    input  logic                  tx_start,
    input  logic [FRAME_BITS-1:0] tx_frame,
    output logic                  line_out,
    output logic                  rx_valid,
    output logic [FRAME_BITS-1:0] rx_frame,
    output logic                  fault_active,
    output logic                  disc_flag,
    output logic [CNT_W-1:0]      corrupt_count
);
    import fi_pkg::*;

    fault_mode_e           mode_q;
    logic [FRAME_BITS-1:0] param_q;
    logic                  win_active, osc_level, busy, cur_bit, changed;
    logic                  pass_bit, drift_en;

    // Configuration registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q  <= FM_NONE;
            param_q <= '0;
        end else if (cfg_load) begin
            mode_q  <= fault_mode_e'(cfg_mode);
            param_q <= cfg_param;
        end
    end

    fi_window #(.TIME_W(TIME_W)) u_win (
        .clk(clk), .rst_n(rst_n), .load(cfg_load),
        .start_in(cfg_start), .dur_in(cfg_dur), .active(win_active)
    );

    fi_osc #(.OSC_W(OSC_W)) u_osc (
        .clk(clk), .rst_n(rst_n),
        .en(win_active && (mode_q == FM_OSC)),
        .period(param_q[OSC_W-1:0]), .level(osc_level)
    );

    fi_frame #(.FRAME_BITS(FRAME_BITS)) u_frame (
        .clk(clk), .rst_n(rst_n), .start(tx_start), .frame_in(tx_frame),
        .line_bit(line_out), .drift_en(drift_en), .drift_off(param_q),
        .busy(busy), .cur_bit(cur_bit), .rx_valid(rx_valid),
        .rx_frame(rx_frame), .changed(changed)
    );

    // Line selection per fault mode.
    always_comb begin
        pass_bit     = busy ? cur_bit : IDLE_LEVEL;
        fault_active = win_active && (mode_q != FM_NONE);
        drift_en     = win_active && (mode_q == FM_DRIFT);
        disc_flag    = win_active && (mode_q == FM_DISC);
        line_out     = pass_bit;
        if (win_active) begin
            case (mode_q)
                FM_SHORT:   line_out = 1'b0;
                FM_STUCK:   line_out = param_q[0];
                FM_DISC:    line_out = IDLE_LEVEL;
                FM_CORRUPT: line_out = busy ? ~cur_bit : IDLE_LEVEL;
                FM_OSC:     line_out = osc_level;
                default:    line_out = pass_bit;
            endcase
        end
    end

    // Saturating count of altered frames.
    always_ff @(posedge clk) begin
        if (!rst_n)
            corrupt_count <= '0;
        else if (changed && (corrupt_count != '1))
            corrupt_count <= corrupt_count + 1'b1;
    end
endmodule

// File: rtl/serial_fault_injector_chk.sv
// Checker for serial_fault_injector, attached by bind.
module serial_fault_injector_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             line_out,
    input logic             rx_valid,
    input logic             fault_active,
    input logic             disc_flag,
    input logic             busy,
    input logic [2:0]       mode,
    input logic [CNT_W-1:0] corrupt_count
);
    // R6: a disconnect holds the line at idle level.
    a_r6_disc_idle: assert property (@(posedge clk) disable iff (!rst_n)
        disc_flag |-> line_out);
    // R2: delivery strobe lasts one cycle.
    a_r2_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);
    // R11: count moves only by one, right after a delivery.
    a_r11_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        (corrupt_count != $past(corrupt_count)) |->
            ($past(rx_valid) && corrupt_count == $past(corrupt_count) + 1'b1));
    // R4: a short pulls the line low.
    a_r4_short_low: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_active && mode == 3'd1) |-> !line_out);
    // R1: with no fault and no frame the line is idle.
    a_r1_idle_line: assert property (@(posedge clk) disable iff (!rst_n)
        (!fault_active && !busy) |-> line_out);
endmodule

bind serial_fault_injector serial_fault_injector_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .line_out(line_out), .rx_valid(rx_valid),
    .fault_active(fault_active), .disc_flag(disc_flag), .busy(busy),
    .mode(mode_q), .corrupt_count(corrupt_count)
);

// File: tb/serial_fault_injector_test.sv
module serial_fault_injector_test;
    localparam logic [31:0] F = 32'hA5C3_0F96;
    localparam logic [31:0] G = 32'h1234_5678;
    localparam int NV = 11;
    localparam logic [2:0]  V_MODE  [NV] = '{3'd0, 3'd4, 3'd4, 3'd1, 3'd2, 3'd3, 3'd5, 3'd5, 3'd1, 3'd4, 3'd6};
    localparam logic [15:0] V_START [NV] = '{16'd0, 16'd5, 16'd1, 16'd0, 16'd9, 16'd17, 16'd0, 16'd33, 16'd33, 16'd32, 16'd1};
    localparam logic [15:0] V_DUR   [NV] = '{16'd0, 16'd1, 16'd3, 16'd0, 16'd8, 16'd0, 16'd0, 16'd0, 16'd0, 16'd1, 16'd0};
    localparam logic [31:0] V_PARAM [NV] = '{32'd0, 32'd0, 32'd0, 32'd0, 32'd1, 32'd0, 32'h10, 32'h10, 32'd0, 32'd0, 32'd2};
    localparam logic [31:0] V_EXP   [NV] = '{F, F ^ 32'h10, F ^ 32'h7, 32'h0, F | 32'h0000_FF00,
                                             F | 32'hFFFF_0000, F + 32'h10, F, F, F ^ 32'h8000_0000, 32'hCCCC_CCCC};

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        cfg_load = 1'b0, tx_start = 1'b0;
    logic [2:0]  cfg_mode = 3'd0;
    logic [15:0] cfg_start = '0, cfg_dur = '0;
    logic [31:0] cfg_param = '0, tx_frame = '0;
    logic        line_out, rx_valid, fault_active, disc_flag;
    logic [31:0] rx_frame;
    logic [15:0] corrupt_count;
    int checks = 0, fails = 0, exp_cnt = 0;
    bit done = 0;

    always #5 clk = ~clk;

    serial_fault_injector uut (
        .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_mode(cfg_mode),
        .cfg_start(cfg_start), .cfg_dur(cfg_dur), .cfg_param(cfg_param),
        .tx_start(tx_start), .tx_frame(tx_frame), .line_out(line_out),
        .rx_valid(rx_valid), .rx_frame(rx_frame), .fault_active(fault_active),
        .disc_flag(disc_flag), .corrupt_count(corrupt_count)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic load(input logic [2:0] m, input logic [15:0] s, input logic [15:0] d, input logic [31:0] p);
        cfg_load = 1'b1; cfg_mode = m; cfg_start = s; cfg_dur = d; cfg_param = p;
        @(negedge clk);
        cfg_load = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] seen;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 line", {31'b0, line_out}, 32'd1);
        chk("R1 valid", {31'b0, rx_valid}, 32'd0);
        chk("R1 active", {31'b0, fault_active}, 32'd0);
        chk("R1 disc", {31'b0, disc_flag}, 32'd0);
        chk("R1 count", {16'b0, corrupt_count}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // Vector table: R2 R4 R5 R6 R7 R8 R9
        for (int v = 0; v < NV; v++) begin
            load(V_MODE[v], V_START[v], V_DUR[v], V_PARAM[v]);
            // cycle with timer 0: drive the strobe here
            cfg_load = 1'b0;
            tx_start = 1'b1; tx_frame = F;
            @(negedge clk);
            tx_start = 1'b0;
            seen = '0;
            seen[0] = line_out;
            for (int p = 1; p < 32; p++) begin
                @(negedge clk);
                seen[p] = line_out;
            end
            @(negedge clk);
            chk($sformatf("R2/R4-R9 line v%0d", v), seen, (V_MODE[v] == 3'd5) ? F : V_EXP[v]);
            chk($sformatf("R2 valid v%0d", v), {31'b0, rx_valid}, 32'd1);
            chk($sformatf("R2/R8 frame v%0d", v), rx_frame, V_EXP[v]);
            if (V_EXP[v] != F) exp_cnt++;
        end
        @(negedge clk);
        chk("R11 count", {16'b0, corrupt_count}, exp_cnt);

        // R3 window timing and R4 idle line under short
        load(3'd1, 16'd5, 16'd3, 32'd0);
        for (int t = 0; t < 10; t++) begin
            chk($sformatf("R3 active t%0d", t), {31'b0, fault_active}, (t >= 5 && t < 8) ? 1 : 0);
            chk($sformatf("R4 line t%0d", t), {31'b0, line_out}, (t >= 5 && t < 8) ? 0 : 1);
            @(negedge clk);
        end

        // R6 disconnect flag
        load(3'd3, 16'd0, 16'd0, 32'd0);
        chk("R6 flag", {31'b0, disc_flag}, 32'd1);
        chk("R6 line", {31'b0, line_out}, 32'd1);

        // R9 oscillation line, half-period 3
        load(3'd6, 16'd0, 16'd0, 32'd3);
        for (int t = 0; t < 9; t++) begin
            chk($sformatf("R9 osc t%0d", t), {31'b0, line_out}, ((t / 3) % 2 == 1) ? 1 : 0);
            @(negedge clk);
        end

        // R7 corruption outside a frame leaves the line idle
        load(3'd4, 16'd0, 16'd0, 32'd0);
        chk("R7 idle", {31'b0, line_out}, 32'd1);

        // R10 start during a frame in flight is ignored
        load(3'd0, 16'd0, 16'd0, 32'd0);
        tx_start = 1'b1; tx_frame = F;
        @(negedge clk);
        tx_start = 1'b0;
        repeat (10) @(negedge clk);
        tx_start = 1'b1; tx_frame = G;
        @(negedge clk);
        tx_start = 1'b0;
        repeat (21) @(negedge clk);
        chk("R10 valid", {31'b0, rx_valid}, 32'd1);
        chk("R10 frame", rx_frame, F);
        begin
            int extra = 0;
            for (int t = 0; t < 40; t++) begin
                @(negedge clk);
                if (rx_valid) extra++;
            end
            chk("R10 no extra frame", extra, 32'd0);
        end
        chk("R11 count unchanged", {16'b0, corrupt_count}, exp_cnt);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule